// File: doc/BRIEF.md
# Serial Password Check with Attempt Counter

This block guards the protected regions of a bit-serial secure memory. The host presents a 16-bit password one bit per operation while the memory's address walks through the password word. Every presented bit is compared with the bit stored at that address, and one sticky mismatch flag collects the result. The password alone does not unlock anything. The host must then pick a counter bit that is still 1 in the first byte of the attempt-counter word, write that bit to 0, and erase the same bit. The block sets its unlock flag only when every compared bit matched and this write-then-erase step was completed in order.

Each write in the confirmation step uses up one attempt. The erase that follows restores the whole counter word, and the block forwards that erase only when the password matched, so a wrong attempt stays recorded in the array. When all eight attempt bits have been seen at 0, the block reports a lockout and refuses any further counter write, so the unlock flag can no longer be set. The lockout is derived from stored bits that the block observes, so it returns after a reset as soon as the host walks the counter again. The unlock flag is cleared only by the power-on reset input.

The memory array lives outside the block. The block sees the current address, the operation and the stored bit at that address. It returns one-cycle write and erase requests, which the array applies at the next rising clock edge.

Top module: `pwd_gate`

## Requirements
- R1: After reset, sv_o, confirm_o and lock_o are 0, and no write or erase request is raised.
- R2: Operation codes on op_i are 0 = advance/read, 1 = compare, 2 = write, 3 = erase. A compare at address 80 starts an attempt. Compares at 81 through 95 must follow in order. If every host bit equals the stored bit and the step in R4 and R5 then completes, sv_o and confirm_o are 1 after the erase edge and er_req_o is raised for that erase.
- R3: If any of the 16 compared bits differs, the completing erase leaves sv_o at 0 and confirm_o at 0, and raises no erase request while sv_o is 0.
- R4: After a full compare, a write at an address from 96 to 103 whose stored bit is 1 raises wr_req_o. A write to a bit that is already 0 raises no request and aborts the attempt.
- R5: The erase must target the same address as the confirming write. An erase at any other address raises no request and leaves sv_o at 0.
- R6: Any out-of-order operation aborts the attempt without setting sv_o. This includes an erase without the preceding write, and a compare at the wrong address.
- R7: An erase anywhere in addresses 96 to 111 raises er_req_o only if sv_o is already 1 or a correct attempt completes with it. Outside an attempt and with sv_o at 0, it raises nothing.
- R8: Once set, sv_o stays 1 through later failed attempts. Only rst_n clears it.
- R9: lock_o is 1 once each of addresses 96 to 103 has been observed at 0 through an operation or a granted write. While it is 1, no counter write is granted, so a correct password cannot set sv_o. After a reset, walking the counter again restores lock_o from the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Power-on reset, active low |
| op_valid_i | input | 1 | An operation is applied this cycle |
| op_i | input | 2 | Operation code (see R2) |
| addr_i | input | AW (11) | Current bit address of the memory |
| host_bit_i | input | 1 | Data bit presented by the host |
| mem_bit_i | input | 1 | Stored bit at addr_i |
| sv_o | output | 1 | Sticky password-validated flag |
| confirm_o | output | 1 | Result of the last completed confirmation step |
| lock_o | output | 1 | All eight attempt bits observed at 0 |
| wr_req_o | output | 1 | Write the bit at addr_i to 0 at the next edge |
| er_req_o | output | 1 | Erase the whole counter word at the next edge |

## Verification
Assertions check the following on every cycle:
- sv_o never falls outside reset.
- An erase request is always followed by sv_o being set.
- confirm_o never rises without sv_o.
- Two counter writes are never granted back to back.
- lock_o only drops together with a counter erase.

Only the bench scenarios can show which operation sequences count as a complete attempt, and that one flipped bit defeats it. They also show that a used attempt bit stays consumed and that lockout follows from the stored counter after a reset.

// File: rtl/pwd_gate.sv
module pwd_gate #(
  parameter int AW       = 11,
  parameter int PW_BASE  = 80,
  parameter int PW_LEN   = 16,
  parameter int CNT_BASE = 96,
  parameter int CNT_LEN  = 16,
  parameter int TRY_LEN  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic          host_bit_i,
  input  logic          mem_bit_i,
  output logic          sv_o,
  output logic          confirm_o,
  output logic          lock_o,
  output logic          wr_req_o,
  output logic          er_req_o
);
  localparam int IW = $clog2(PW_LEN + 1);
  localparam logic [AW-1:0] PW_FIRST  = AW'(PW_BASE);
  localparam logic [AW-1:0] CNT_FIRST = AW'(CNT_BASE);
  localparam logic [AW-1:0] CNT_LAST  = AW'(CNT_BASE + CNT_LEN - 1);
  localparam logic [AW-1:0] TRY_LAST  = AW'(CNT_BASE + TRY_LEN - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(PW_LEN - 1);

  localparam logic [1:0] OP_INC = 2'd0;
  localparam logic [1:0] OP_CMP = 2'd1;
  localparam logic [1:0] OP_WR  = 2'd2;
  localparam logic [1:0] OP_ER  = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_CMP, S_WAIT_WR, S_WAIT_ER} st_t;

  st_t                st_q;
  logic [IW-1:0]      idx_q;
  logic               miss_q;
  logic [AW-1:0]      slot_q;
  logic               sv_q;
  logic               conf_q;
  logic [TRY_LEN-1:0] seen_q;

  wire in_try = (addr_i >= CNT_FIRST) && (addr_i <= TRY_LAST);
  wire in_cnt = (addr_i >= CNT_FIRST) && (addr_i <= CNT_LAST);
  wire is_inc = op_valid_i && (op_i == OP_INC);
  wire is_cmp = op_valid_i && (op_i == OP_CMP);
  wire is_wr  = op_valid_i && (op_i == OP_WR);
  wire is_er  = op_valid_i && (op_i == OP_ER);
  wire diff   = host_bit_i ^ mem_bit_i;

  wire cmp_start = is_cmp && (addr_i == PW_FIRST);
  wire cmp_next  = (st_q == S_CMP) && is_cmp && (addr_i == PW_FIRST + AW'(idx_q));
  wire wr_ok     = (st_q == S_WAIT_WR) && is_wr && in_try && mem_bit_i && !lock_o;
  wire finish    = (st_q == S_WAIT_ER) && is_er && (addr_i == slot_q);

  assign wr_req_o  = wr_ok;
  assign er_req_o  = is_er && in_cnt && (sv_q || (finish && !miss_q));
  assign sv_o      = sv_q;
  assign confirm_o = conf_q;
  assign lock_o    = &seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      miss_q <= 1'b0;
      slot_q <= '0;
      sv_q   <= 1'b0;
      conf_q <= 1'b0;
    end else if (op_valid_i) begin
      conf_q <= 1'b0;
      if (cmp_start) begin
        st_q   <= (PW_LEN == 1) ? S_WAIT_WR : S_CMP;
        idx_q  <= IW'(1);
        miss_q <= diff;
      end else begin
        case (st_q)
          S_CMP: begin
            if (cmp_next) begin
              miss_q <= miss_q | diff;
              idx_q  <= idx_q + IW'(1);
              if (idx_q == IDX_LAST) st_q <= S_WAIT_WR;
            end else begin
              st_q <= S_IDLE;
            end
          end
          S_WAIT_WR: begin
            if (wr_ok) begin
              st_q   <= S_WAIT_ER;
              slot_q <= addr_i;
            end else if (!(is_inc && in_try)) begin
              st_q <= S_IDLE;
            end
          end
          S_WAIT_ER: begin
            st_q <= S_IDLE;
            if (finish && !miss_q) begin
              sv_q   <= 1'b1;
              conf_q <= 1'b1;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (er_req_o) begin
      seen_q <= '0;
    end else if (op_valid_i) begin
      for (int i = 0; i < TRY_LEN; i++) begin
        if (addr_i == AW'(CNT_BASE + i)) seen_q[i] <= wr_req_o | ~mem_bit_i;
      end
    end
  end

  // R8
  sv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sv_q |=> sv_q);

  // R7
  erase_needs_sv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    er_req_o |=> sv_q);

  // R2
  confirm_with_sv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conf_q) |-> sv_q);

  // R4
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |=> !wr_req_o);

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !er_req_o) |=> lock_o);
endmodule

// File: tb/pwd_gate_tb.sv
`timescale 1ns/100ps
module pwd_gate_tb_top;
  localparam int AW = 11;
  localparam logic [15:0] PW = 16'hA5C3;
  localparam logic [1:0] OP_INC = 2'd0, OP_CMP = 2'd1, OP_WR = 2'd2, OP_ER = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op = '0;
  logic [AW-1:0] addr = '0;
  logic host = 1'b0;
  logic mem_bit;
  logic sv, conf, lock, wr_req, er_req;
  logic mem [0:(1<<AW)-1];
  logic last_wr, last_er;
  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign mem_bit = mem[addr];

  pwd_gate dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_i(op), .addr_i(addr),
    .host_bit_i(host), .mem_bit_i(mem_bit), .sv_o(sv), .confirm_o(conf),
    .lock_o(lock), .wr_req_o(wr_req), .er_req_o(er_req)
  );

  always @(posedge clk) begin
    if (wr_req) mem[addr] <= 1'b0;
    if (er_req) for (int i = 96; i < 112; i++) mem[i] <= 1'b1;
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] o, input int a, input logic h);
    @(negedge clk);
    op_valid = 1'b1; op = o; addr = AW'(a); host = h;
    #1;
    last_wr = wr_req; last_er = er_req;
    @(posedge clk); #1;
    op_valid = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic compare(input int flip);
    for (int i = 0; i < 16; i++) do_op(OP_CMP, 80 + i, PW[i] ^ (i == flip));
  endtask

  task automatic find_free(output int slot);
    slot = -1;
    for (int a = 96; a < 104; a++) begin
      if (mem[a] === 1'b1) begin slot = a; return; end
      do_op(OP_INC, a, 1'b0);
    end
  endtask

  task automatic t_reset();
    check("R1 sv after reset", sv, 1'b0);
    check("R1 confirm after reset", conf, 1'b0);
    check("R1 lock after reset", lock, 1'b0);
    check("R1 no write req", wr_req, 1'b0);
    check("R1 no erase req", er_req, 1'b0);
  endtask

  task automatic t_wrong_pw();
    int s;
    compare(5);
    find_free(s);
    do_op(OP_WR, s, 1'b0);
    check("R4 write granted at free bit", last_wr, 1'b1);
    do_op(OP_ER, s, 1'b1);
    check("R3 no erase on mismatch", last_er, 1'b0);
    check("R3 confirm stays 0", conf, 1'b0);
    check("R3 sv stays 0", sv, 1'b0);
    check("R3 attempt bit consumed", mem[s], 1'b0);
  endtask

  task automatic t_out_of_order();
    compare(-1);
    do_op(OP_ER, 97, 1'b1);
    check("R6 erase without write", last_er, 1'b0);
    check("R6 sv stays 0", sv, 1'b0);
    compare(-1);
    do_op(OP_WR, 97, 1'b0);
    check("R4 write granted", last_wr, 1'b1);
    do_op(OP_ER, 98, 1'b1);
    check("R5 erase at other address", last_er, 1'b0);
    check("R5 sv stays 0", sv, 1'b0);
    do_op(OP_CMP, 80, PW[0]);
    do_op(OP_CMP, 82, PW[2]);
    do_op(OP_WR, 99, 1'b0);
    check("R6 compare skipped address", last_wr, 1'b0);
  endtask

  task automatic t_used_bit();
    compare(-1);
    do_op(OP_WR, 96, 1'b0);
    check("R4 write at used bit", last_wr, 1'b0);
    do_op(OP_ER, 96, 1'b1);
    check("R4 no erase after refused write", last_er, 1'b0);
    check("R4 sv stays 0", sv, 1'b0);
  endtask

  task automatic t_erase_no_sv();
    do_op(OP_ER, 100, 1'b1);
    check("R7 counter erase without sv", last_er, 1'b0);
    check("R7 bit untouched", mem[96], 1'b0);
  endtask

  task automatic t_good();
    int s;
    compare(-1);
    find_free(s);
    check("R2 free slot found", (s == 98), 1'b1);
    do_op(OP_WR, s, 1'b0);
    check("R2 write granted", last_wr, 1'b1);
    do_op(OP_ER, s, 1'b1);
    check("R2 erase issued", last_er, 1'b1);
    check("R2 sv set", sv, 1'b1);
    check("R2 confirm set", conf, 1'b1);
    check("R7 counter word restored", mem[96] & mem[97] & mem[111], 1'b1);
  endtask

  task automatic t_sticky();
    int s;
    compare(2);
    find_free(s);
    do_op(OP_WR, s, 1'b0);
    do_op(OP_ER, s, 1'b1);
    check("R8 sv stays after failed attempt", sv, 1'b1);
    check("R3 confirm 0 on failed attempt", conf, 1'b0);
    check("R7 erase allowed with sv", last_er, 1'b1);
    do_op(OP_ER, 105, 1'b1);
    check("R7 idle erase with sv", last_er, 1'b1);
    pulse_reset();
    check("R8 sv cleared by reset", sv, 1'b0);
  endtask

  task automatic t_lockout();
    int s;
    for (int k = 0; k < 8; k++) begin
      compare(k);
      find_free(s);
      do_op(OP_WR, s, 1'b0);
      do_op(OP_ER, s, 1'b1);
      if (k == 6) check("R9 not locked with one bit left", lock, 1'b0);
    end
    check("R9 lock after eight attempts", lock, 1'b1);
    pulse_reset();
    check("R9 lock cleared by reset until walked", lock, 1'b0);
    for (int a = 96; a < 104; a++) do_op(OP_INC, a, 1'b0);
    check("R9 lock restored from stored bits", lock, 1'b1);
    compare(-1);
    do_op(OP_WR, 103, 1'b0);
    check("R9 write refused when locked", last_wr, 1'b0);
    do_op(OP_ER, 103, 1'b1);
    check("R9 no erase when locked", last_er, 1'b0);
    check("R9 sv stays 0 when locked", sv, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 1'b1;
    for (int i = 0; i < 16; i++) mem[80 + i] = PW[i];
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_wrong_pw();
    t_out_of_order();
    t_used_bit();
    t_erase_no_sv();
    t_good();
    t_sticky();
    t_lockout();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule